// File: doc/BRIEF.md
# Oscillator Tuning Word Encoder with Sigma-Delta Dither

This block turns a packed oscillator tuning word into the switch controls of a digitally tuned oscillator. The word has three fields. The upper field selects binary-weighted coarse elements directly. The middle field is a fine integer that becomes a thermometer code over unit-weighted elements, so each fine step adds exactly one element and the response stays monotonic. The lower field is a fraction. A first-order sigma-delta modulator turns it into a bit stream that switches one extra unit element on and off.

All logic runs on the dither clock, which is meant to run faster than the rate at which the tuning word changes. The modulator therefore oversamples the fraction. The long-run average of the extra element equals the fraction, which gives resolution finer than one unit element. Only unit elements are ever dithered, so the gain per dither step is exactly one fine step. The tuning word is captured at a clock edge. The outputs are registered one edge later.

Top module: `dco_tw_encoder`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the block clears the accumulator and the captured word. From the following edge on, `coarse_out` and `unit_out` are all zeros, which is the minimum-frequency code.
- R2: `coarse_out` equals the coarse field `tune_word[FRAC_W+FINE_W +: COARSE_W]` and is passed on unchanged as a binary value.
- R3: `unit_out` is a thermometer code. Bit i is high exactly when the effective count is greater than i. The effective count is the fine field `tune_word[FRAC_W +: FINE_W]` plus the dither bit.
- R4: The dither bit is the carry out of a FRAC_W-bit accumulator that adds the fraction field `tune_word[FRAC_W-1:0]` on every clock. While the fraction is held at value F, any 2^FRAC_W consecutive cycles contain exactly F dither pulses.
- R5: When the fine field is at its maximum (2^FINE_W-1), a dither pulse saturates and `unit_out` stays all ones. It never wraps to fewer elements.
- R6: A `tune_word` value sampled at clock edge k first appears on the outputs just after edge k+1. Just after edge k the outputs still show the previous word.
- R7: While the fraction field is zero, no dither pulse occurs. `unit_out` then holds exactly the fine-field number of ones.
- R8: The number of ones in `unit_out` is never below the fine value and never more than one above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dither clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | COARSE_W+FINE_W+FRAC_W | Packed tuning word: coarse field on top, fine field in the middle, fraction field at the bottom |
| coarse_out | output | COARSE_W | Binary-weighted coarse element enables |
| unit_out | output | 2^FINE_W-1 | Unit-element enables: thermometer code of the fine value with the dither bit added |

## Verification
Every output is due two rising edges after the tuning word is presented: one edge to capture the word and one edge to register the encoded result. The dither pulse in a given output cycle comes from the accumulator state that the same edge updates. The bench keeps a behavioural model that captures the word and steps the accumulator on the same edges. It compares both buses at every falling edge, after the last edge that could have moved them. The latency, density, saturation and zero-fraction checks all sample at falling edges counted from the edge at which the word was applied. The density windows are exactly 2^FRAC_W cycles long, so the pulse count is exact whatever the accumulator held at the start of the window.

// File: rtl/dco_enc_pkg.sv
package dco_enc_pkg;

  // Saturating sum of two non-negative counts, limited to lim.
  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

endpackage

// File: rtl/dco_tw_capture.sv
module dco_tw_capture #(
  parameter int TW_W = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW_W-1:0] word_in,
  output logic [TW_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_in;
  end

endmodule

// File: rtl/dco_sd_first.sv
module dco_sd_first #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, frac};
    carry = sum[FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum[FRAC_W-1:0];
  end

endmodule

// File: rtl/dco_therm_enc.sv
module dco_therm_enc #(
  parameter int FINE_W = 3,
  localparam int UNITS = (1 << FINE_W) - 1,
  localparam int CNT_W = FINE_W + 1
) (
  input  logic [FINE_W-1:0] fine,
  input  logic              dither,
  output logic [UNITS-1:0]  therm
);

  logic [CNT_W-1:0] cnt_sat;

  always_comb begin
    cnt_sat = CNT_W'(dco_enc_pkg::sat_add(int'(fine), int'(dither), UNITS));
  end

  for (genvar i = 0; i < UNITS; i++) begin : g_unit
    assign therm[i] = (cnt_sat > CNT_W'(i));
  end

endmodule

// File: rtl/dco_tw_encoder.sv
module dco_tw_encoder #(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 3,
  parameter int FRAC_W   = 4,
  localparam int TW_W    = COARSE_W + FINE_W + FRAC_W,
  localparam int UNITS   = (1 << FINE_W) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TW_W-1:0]     tune_word,
  output logic [COARSE_W-1:0] coarse_out,
  output logic [UNITS-1:0]    unit_out
);

  logic [TW_W-1:0]     tw_q;
  logic [FRAC_W-1:0]   frac_q;
  logic [FINE_W-1:0]   fine_q;
  logic [COARSE_W-1:0] coarse_q;
  logic                dith;
  logic [UNITS-1:0]    therm;

  dco_tw_capture #(.TW_W(TW_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .word_in (tune_word),
    .word_q  (tw_q)
  );

  assign frac_q   = tw_q[FRAC_W-1:0];
  assign fine_q   = tw_q[FRAC_W +: FINE_W];
  assign coarse_q = tw_q[FRAC_W+FINE_W +: COARSE_W];

  dco_sd_first #(.FRAC_W(FRAC_W)) u_sd (
    .clk   (clk),
    .rst   (rst),
    .frac  (frac_q),
    .carry (dith)
  );

  dco_therm_enc #(.FINE_W(FINE_W)) u_therm (
    .fine   (fine_q),
    .dither (dith),
    .therm  (therm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_out <= '0;
      unit_out   <= '0;
    end else begin
      coarse_out <= coarse_q;
      unit_out   <= therm;
    end
  end

endmodule

// File: rtl/dco_tw_encoder_chk.sv
module dco_tw_encoder_chk #(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 3,
  parameter int FRAC_W   = 4,
  localparam int TW_W    = COARSE_W + FINE_W + FRAC_W,
  localparam int UNITS   = (1 << FINE_W) - 1
) (
  input logic                clk,
  input logic                rst,
  input logic [TW_W-1:0]     tune_word,
  input logic [COARSE_W-1:0] coarse_out,
  input logic [UNITS-1:0]    unit_out
);

  // Counts edges since reset; outputs track a past word once it reaches 2.
  logic [1:0] since_rst;
  logic       tracking;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign tracking = since_rst[1];

  assert_reset_code_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (coarse_out == '0 && unit_out == '0));

  assert_coarse_pass_R2: assert property (@(posedge clk) disable iff (rst)
    tracking |-> coarse_out == $past(tune_word[FRAC_W+FINE_W +: COARSE_W], 2));

  assert_therm_shape_R3: assert property (@(posedge clk) disable iff (rst)
    ((unit_out + UNITS'(1)) & unit_out) == '0);

  assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    (tracking && $past(tune_word[FRAC_W +: FINE_W], 2) == FINE_W'(UNITS)) |-> (&unit_out));

  assert_zero_frac_R7: assert property (@(posedge clk) disable iff (rst)
    (tracking && $past(tune_word[FRAC_W-1:0], 2) == '0) |->
      ($countones(unit_out) == int'($past(tune_word[FRAC_W +: FINE_W], 2))));

  assert_one_extra_R8: assert property (@(posedge clk) disable iff (rst)
    tracking |->
      ($countones(unit_out) >= int'($past(tune_word[FRAC_W +: FINE_W], 2)) &&
       $countones(unit_out) <= int'($past(tune_word[FRAC_W +: FINE_W], 2)) + 1));

endmodule

bind dco_tw_encoder dco_tw_encoder_chk #(
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W),
  .FRAC_W   (FRAC_W)
) i_chk (.*);

// File: tb/test_dco_tw_encoder.sv
module test_dco_tw_encoder;

  localparam int CW    = 6;
  localparam int FI    = 3;
  localparam int FR    = 4;
  localparam int TW    = CW + FI + FR;
  localparam int UNITS = (1 << FI) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] tune_word = '0;
  logic [CW-1:0] coarse_out;
  logic [UNITS-1:0] unit_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit started = 1'b0;

  // behavioural reference state
  int twq_m = 0, acc_m = 0, exp_c = 0, exp_u = 0, exp_f = 0;

  always #10 clk = ~clk;

  dco_tw_encoder #(.COARSE_W(CW), .FINE_W(FI), .FRAC_W(FR)) i_dco_tw_encoder (
    .clk        (clk),
    .rst        (rst),
    .tune_word  (tune_word),
    .coarse_out (coarse_out),
    .unit_out   (unit_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // reference model, stepped on every rising edge
  always @(posedge clk) begin
    int c, f, fr, s, cy, n;
    started = 1'b1;
    if (rst) begin
      acc_m = 0; twq_m = 0; exp_c = 0; exp_u = 0; exp_f = 0;
    end else begin
      c  = twq_m >> (FI + FR);
      f  = (twq_m >> FR) % (1 << FI);
      fr = twq_m % (1 << FR);
      s  = acc_m + fr;
      cy = (s >= (1 << FR)) ? 1 : 0;
      acc_m = s % (1 << FR);
      n = f + cy;
      if (n > UNITS) n = UNITS;
      exp_c = c;
      exp_u = (1 << n) - 1;
      exp_f = f;
      twq_m = int'(tune_word);
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (started && !done) begin
      int ones;
      ones = $countones(unit_out);
      chk(int'(coarse_out) == exp_c, "R2 coarse", int'(coarse_out), exp_c);
      chk(int'(unit_out) == exp_u, "R3 unit", int'(unit_out), exp_u);
      chk(ones >= exp_f && ones <= exp_f + 1, "R8 extra", ones, exp_f);
    end
  end

  task automatic apply(input int c, input int f, input int fr);
    @(negedge clk);
    tune_word <= TW'((c << (FI + FR)) | (f << FR) | fr);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts dither pulses over one full accumulator period
  task automatic density(input int f, input int fr, input string tag);
    int pulses = 0;
    apply(3, f, fr);
    wait_n(2);
    for (int k = 0; k < (1 << FR); k++) begin
      if (k != 0) @(negedge clk);
      pulses += $countones(unit_out) - f;
    end
    chk(pulses == fr, tag, pulses, fr);
  endtask

  initial begin
    rst = 1'b1;
    wait_n(3);
    // R1: minimum-frequency code under reset
    chk(coarse_out == '0 && unit_out == '0, "R1 reset code", int'(unit_out), 0);
    apply(9, 4, 0);
    rst <= 1'b0;
    wait_n(1);
    chk(coarse_out == '0, "R1 first cycle", int'(coarse_out), 0);
    wait_n(2);

    // R6: latency of two edges
    apply(5, 2, 0);
    wait_n(1);
    chk(int'(coarse_out) == 9, "R6 old word held", int'(coarse_out), 9);
    wait_n(1);
    chk(int'(coarse_out) == 5, "R6 new word", int'(coarse_out), 5);

    // R3: fine sweep with no fraction
    for (int f = 0; f <= UNITS; f++) begin
      apply(f * 7, f, 0);
      wait_n(2);
      chk(int'(unit_out) == (1 << f) - 1, "R3 sweep", int'(unit_out), (1 << f) - 1);
    end

    // R7: zero fraction never dithers
    begin
      int bad = 0;
      apply(12, 2, 0);
      wait_n(2);
      for (int k = 0; k < 20; k++) begin
        if ($countones(unit_out) != 2) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R7 no dither", bad, 0);
    end

    // R4: exact pulse density per period
    density(1, 5, "R4 density 5/16");
    density(3, 1, "R4 density 1/16");
    density(0, 15, "R4 density 15/16");
    density(4, 8, "R4 density 8/16");

    // R5: saturation at maximum fine value
    begin
      int bad = 0;
      apply(63, UNITS, 9);
      wait_n(2);
      for (int k = 0; k < (1 << FR); k++) begin
        if (unit_out != {UNITS{1'b1}}) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R5 saturation", bad, 0);
    end

    // R2: mixed words, checked by the per-cycle model
    begin
      int x = 37;
      for (int k = 0; k < 60; k++) begin
        x = (x * 13 + 7) % (1 << TW);
        @(negedge clk);
        tune_word <= TW'(x);
        if (k % 3 == 0) wait_n(2);
      end
      wait_n(3);
    end

    // R1: reset in mid-run returns to the minimum code
    apply(40, 6, 11);
    wait_n(3);
    rst <= 1'b1;
    wait_n(2);
    chk(coarse_out == '0 && unit_out == '0, "R1 mid-run reset", int'(unit_out), 0);
    rst <= 1'b0;
    wait_n(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule